// File: doc/BRIEF.md
# Slave Port Crossbar Arbiter

This block decides which of four bus masters owns a single slave port of a crossbar. Each master presents a request with a 32-bit address, 64-bit write data and a write flag. When the port is free, the arbiter picks one requester. It registers that master as the owner and steers the owner's address, data and write flag to the slave side. Every other requester sees no grant and stalls. Ownership lasts until the slave side raises a one-cycle done pulse. The port is then free for one cycle, and the next owner is chosen in that cycle.

Two selection schemes are available, chosen by a mode input. Rotating mode gives all masters equal weight and searches onward from the master that was granted last. Fixed mode uses a 2-bit priority per master that software writes at run time. Each master also has a boost input that lifts it above every master that is not boosted, for as long as the input is held. Mode, priority values and boost inputs are only looked at in the cycle where a choice is made, so none of them can disturb an ongoing grant.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset no grant is asserted, `slv_valid` is 0, and the last-granted master is taken to be master 3. The first rotating-mode choice among all four masters therefore goes to master 0.
- R2: When the port is free and at least one bit of `mst_req` is set, the clock edge that samples the requests makes exactly one master the owner, and that master is a requester. From that edge on, `mst_grant` is one-hot on the owner, `owner_id` holds its index, and `slv_valid` is 1. With no request, the port stays free.
- R3: With `cfg_fixed` = 0 (rotating mode) and no boosted requester, the owner is the first requester found searching upward from (last granted + 1) modulo 4, wrapping around. Every grant in either mode updates the last-granted master.
- R4: With `cfg_fixed` = 1, master i's priority is `cfg_prio[2i+1:2i]`, and 3 is the highest value. The requester with the highest value wins. On equal values the lower master index wins.
- R5: A requester whose `mst_boost` bit is set beats every requester whose bit is clear. In rotating mode the rotation search is made among the boosted requesters only. In fixed mode boosted requesters are compared by their programmed values, with the lower index winning ties.
- R6: While the port is owned and `slv_done` is 0, the owner, `owner_id` and `mst_grant` do not change, whatever the other masters request.
- R7: A `slv_done` pulse while the port is owned frees the port at the next edge, and `slv_valid` then reads 0 for one cycle. Arbitration takes place in that cycle, and a waiting requester is granted at the edge after it. A `slv_done` pulse while the port is free has no effect.
- R8: Changes to `cfg_fixed`, `cfg_prio` or `mst_boost` during a grant leave the current owner in place. The values present at the next arbitration cycle decide the next owner.
- R9: While `slv_valid` is 1, `slv_addr`, `slv_wdata` and `slv_we` equal the owner's `mst_addr[32i+31:32i]`, `mst_wdata[64i+63:64i]` and `mst_we[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_req | input | 4 | Request per master |
| mst_boost | input | 4 | Temporary priority lift per master |
| mst_addr | input | 128 | Master addresses, 32 bits each, master i at bits 32i+31:32i |
| mst_wdata | input | 256 | Master write data, 64 bits each, master i at bits 64i+63:64i |
| mst_we | input | 4 | Write flag per master |
| cfg_fixed | input | 1 | 0 selects rotating mode, 1 selects programmed priority |
| cfg_prio | input | 8 | Programmed 2-bit priority per master, master i at bits 2i+1:2i |
| slv_done | input | 1 | One-cycle pulse that ends the owner's transaction |
| mst_grant | output | 4 | One-hot grant to the owning master |
| owner_id | output | 2 | Index of the owning master |
| slv_valid | output | 1 | Port is owned and the routed signals are live |
| slv_addr | output | 32 | Owner's address |
| slv_wdata | output | 64 | Owner's write data |
| slv_we | output | 1 | Owner's write flag |

## Verification
Requests, mode and priority inputs are driven at the falling edge while the port is free. The registered grant is due at the very next rising edge, so the bench reads `owner_id`, `mst_grant` and the routed signals 1 ns after that edge and compares them with a bench-side model of the rotating and priority rules. A done pulse driven at a falling edge must clear `slv_valid` at the following rising edge. When requests stay high through the release, the bench checks the free cycle first and expects the new owner one edge later. The hold and configuration-change cases read the owner on every cycle of a long grant, and the sweeps cover every request and boost combination in rotating mode and under eight priority patterns.

// File: rtl/spa_pkg.sv
package spa_pkg;
    typedef enum logic {
        ARB_ROTATE = 1'b0,
        ARB_FIXED  = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/spa_rr_pick.sv
module spa_rr_pick #(
    parameter int N_MST = 4,
    localparam int IW = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] cand,
    input  logic [IW-1:0]    last,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    int j;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        j   = 0;
        for (int k = 1; k <= N_MST; k++) begin
            j = (int'(last) + k) % N_MST;
            if (!hit && cand[j]) begin
                hit = 1'b1;
                idx = IW'(j);
            end
        end
    end
endmodule

// File: rtl/spa_prio_pick.sv
module spa_prio_pick #(
    parameter int N_MST = 4,
    parameter int PW    = 2,
    localparam int IW = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]    req,
    input  logic [N_MST-1:0]    boost,
    input  logic [N_MST*PW-1:0] prio,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [PW:0] eff  [N_MST];
    logic [PW:0] best;

    for (genvar g = 0; g < N_MST; g++) begin : g_eff
        assign eff[g] = {boost[g], prio[g*PW +: PW]};
    end

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && (!hit || eff[i] > best)) begin
                hit  = 1'b1;
                idx  = IW'(i);
                best = eff[i];
            end
        end
    end
endmodule

// File: rtl/spa_route_mux.sv
module spa_route_mux #(
    parameter int N_MST = 4,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int IW = $clog2(N_MST)
) (
    input  logic [IW-1:0]       sel,
    input  logic [N_MST*AW-1:0] addr_in,
    input  logic [N_MST*DW-1:0] data_in,
    input  logic [N_MST-1:0]    we_in,
    output logic [AW-1:0]       addr_out,
    output logic [DW-1:0]       data_out,
    output logic                we_out
);
    logic [AW-1:0] addr_arr [N_MST];
    logic [DW-1:0] data_arr [N_MST];

    for (genvar g = 0; g < N_MST; g++) begin : g_unpack
        assign addr_arr[g] = addr_in[g*AW +: AW];
        assign data_arr[g] = data_in[g*DW +: DW];
    end

    assign addr_out = addr_arr[sel];
    assign data_out = data_arr[sel];
    assign we_out   = we_in[sel];
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
    import spa_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int PW    = 2,
    localparam int IW = $clog2(N_MST)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MST-1:0]    mst_req,
    input  logic [N_MST-1:0]    mst_boost,
    input  logic [N_MST*AW-1:0] mst_addr,
    input  logic [N_MST*DW-1:0] mst_wdata,
    input  logic [N_MST-1:0]    mst_we,
    input  logic                cfg_fixed,
    input  logic [N_MST*PW-1:0] cfg_prio,
    input  logic                slv_done,
    output logic [N_MST-1:0]    mst_grant,
    output logic [IW-1:0]       owner_id,
    output logic                slv_valid,
    output logic [AW-1:0]       slv_addr,
    output logic [DW-1:0]       slv_wdata,
    output logic                slv_we
);
    typedef struct packed {
        logic          busy;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    arb_mode_e         mode;
    logic [N_MST-1:0]  boosted_req;
    logic [N_MST-1:0]  rr_cand;
    logic              rr_hit, fx_hit;
    logic [IW-1:0]     rr_idx, fx_idx;
    logic [IW-1:0]     win_idx;

    assign mode        = arb_mode_e'(cfg_fixed);
    assign boosted_req = mst_req & mst_boost;
    assign rr_cand     = (|boosted_req) ? boosted_req : mst_req;

    spa_rr_pick #(.N_MST(N_MST)) rr_i (
        .cand (rr_cand),
        .last (st_q.last),
        .hit  (rr_hit),
        .idx  (rr_idx)
    );

    spa_prio_pick #(.N_MST(N_MST), .PW(PW)) fx_i (
        .req   (mst_req),
        .boost (mst_boost),
        .prio  (cfg_prio),
        .hit   (fx_hit),
        .idx   (fx_idx)
    );

    assign win_idx = (mode == ARB_FIXED) ? fx_idx : rr_idx;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if ((mode == ARB_FIXED) ? fx_hit : rr_hit) begin
                st_d.busy  = 1'b1;
                st_d.owner = win_idx;
                st_d.last  = win_idx;
            end
        end else if (slv_done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.owner <= '0;
            st_q.last  <= IW'(N_MST - 1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_MST; g++) begin : g_grant
        assign mst_grant[g] = st_q.busy && (st_q.owner == IW'(g));
    end

    assign owner_id  = st_q.owner;
    assign slv_valid = st_q.busy;

    spa_route_mux #(.N_MST(N_MST), .AW(AW), .DW(DW)) mux_i (
        .sel      (st_q.owner),
        .addr_in  (mst_addr),
        .data_in  (mst_wdata),
        .we_in    (mst_we),
        .addr_out (slv_addr),
        .data_out (slv_wdata),
        .we_out   (slv_we)
    );
endmodule

// File: rtl/spa_chk.sv
module spa_chk #(
    parameter int N_MST = 4,
    parameter int AW    = 32,
    localparam int IW = $clog2(N_MST)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_MST-1:0]    mst_req,
    input logic [N_MST-1:0]    mst_boost,
    input logic [N_MST*AW-1:0] mst_addr,
    input logic                slv_done,
    input logic [N_MST-1:0]    mst_grant,
    input logic [IW-1:0]       owner_id,
    input logic                slv_valid,
    input logic [AW-1:0]       slv_addr
);
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mst_grant) && (slv_valid == (mst_grant != '0)));

    // R2
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_valid && (mst_req != '0)) |=> (slv_valid && (($past(mst_req) & mst_grant) != '0)));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_valid && (mst_req == '0)) |=> !slv_valid);

    // R5
    boost_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_valid && ((mst_req & mst_boost) != '0))
            |=> ((mst_grant & $past(mst_req & mst_boost)) != '0));

    // R6
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_valid && !slv_done) |=> (slv_valid && $stable(owner_id)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_valid && slv_done) |=> !slv_valid);

    // R9
    route_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_valid |-> (slv_addr == mst_addr[owner_id*AW +: AW]));
endmodule

bind slave_port_arbiter spa_chk #(.N_MST(N_MST), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_req   (mst_req),
    .mst_boost (mst_boost),
    .mst_addr  (mst_addr),
    .slv_done  (slv_done),
    .mst_grant (mst_grant),
    .owner_id  (owner_id),
    .slv_valid (slv_valid),
    .slv_addr  (slv_addr)
);

// File: tb/slave_port_arbiter_tb.sv
`timescale 1ns/1ps
module slave_port_arbiter_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mst_req = '0;
    logic [3:0]   mst_boost = '0;
    logic [127:0] mst_addr;
    logic [255:0] mst_wdata;
    logic [3:0]   mst_we = 4'b0101;
    logic         cfg_fixed = 1'b0;
    logic [7:0]   cfg_prio = '0;
    logic         slv_done = 1'b0;
    logic [3:0]   mst_grant;
    logic [1:0]   owner_id;
    logic         slv_valid;
    logic [31:0]  slv_addr;
    logic [63:0]  slv_wdata;
    logic         slv_we;

    int  total = 0;
    int  bad = 0;
    int  last_id = 3;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    slave_port_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_boost(mst_boost),
        .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_we(mst_we),
        .cfg_fixed(cfg_fixed), .cfg_prio(cfg_prio), .slv_done(slv_done),
        .mst_grant(mst_grant), .owner_id(owner_id), .slv_valid(slv_valid),
        .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_we(slv_we)
    );

    initial begin
        for (int i = 0; i < 4; i++) begin
            mst_addr[i*32 +: 32]  = 32'hA000_0000 + 32'(i * 32'h0101_0010);
            mst_wdata[i*64 +: 64] = 64'hD00D_0000_0000_0000 + 64'(i * 64'h11);
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model(input logic [3:0] r, input logic [3:0] b,
                                 input logic fx, input logic [7:0] p, input int last);
        logic [3:0] c;
        int best;
        int bv;
        best = -1;
        bv = -1;
        if (!fx) begin
            c = ((r & b) != 0) ? (r & b) : r;
            for (int k = 1; k <= 4; k++) begin
                if (best < 0 && c[(last + k) % 4]) best = (last + k) % 4;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                int v;
                v = int'(b[i]) * 4 + int'(p[2*i +: 2]);
                if (r[i] && v > bv) begin
                    bv = v;
                    best = i;
                end
            end
        end
        return best;
    endfunction

    task automatic check_owner(input int e, input string tag);
        chk(slv_valid == 1'b1, {tag, " valid"}, slv_valid, 1);
        chk(owner_id == 2'(e), {tag, " owner"}, owner_id, e);
        chk(mst_grant == 4'(1 << e), {tag, " grant"}, mst_grant, 1 << e);
        chk(slv_addr == mst_addr[e*32 +: 32], "R9 addr", slv_addr, mst_addr[e*32 +: 32]);
        chk(slv_wdata == mst_wdata[e*64 +: 64], "R9 wdata", slv_wdata, mst_wdata[e*64 +: 64]);
        chk(slv_we == mst_we[e], "R9 we", slv_we, mst_we[e]);
    endtask

    // Starts at a falling edge with the port free; returns at a falling edge with it free again.
    task automatic trial(input logic [3:0] r, input logic [3:0] b, input logic fx,
                         input logic [7:0] p, input string tag);
        int e;
        e = model(r, b, fx, p, last_id);
        mst_req = r; mst_boost = b; cfg_fixed = fx; cfg_prio = p;
        @(posedge clk); #1;
        check_owner(e, tag);
        last_id = e;
        @(negedge clk);
        mst_req = '0; slv_done = 1'b1;
        @(posedge clk); #1;
        chk(slv_valid == 1'b0, "R7 release", slv_valid, 0);
        @(negedge clk);
        slv_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(mst_grant == 4'b0, "R1 reset grant", mst_grant, 0);
        chk(slv_valid == 1'b0, "R1 reset valid", slv_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first rotating choice among all four
        mst_req = 4'hF;
        @(posedge clk); #1;
        chk(owner_id == 2'd0, "R1 first owner", owner_id, 0);
        last_id = 0;
        @(negedge clk);
        mst_req = '0; slv_done = 1'b1;
        @(negedge clk);
        slv_done = 1'b0;

        // R6 R8: grant to master 2, then disturb everything during the grant
        mst_req = 4'b0100; cfg_fixed = 1'b0;
        @(posedge clk); #1;
        check_owner(2, "R2 single");
        last_id = 2;
        @(negedge clk);
        mst_req = 4'hF; mst_boost = 4'b0001; cfg_fixed = 1'b1; cfg_prio = 8'h03;
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); #1;
            chk(owner_id == 2'd2 && mst_grant == 4'b0100, "R6 hold", mst_grant, 4'b0100);
            chk(slv_valid == 1'b1, "R8 config during grant", slv_valid, 1);
        end
        @(negedge clk);
        slv_done = 1'b1;
        @(posedge clk); #1;
        chk(slv_valid == 1'b0, "R7 free cycle", slv_valid, 0);
        @(negedge clk);
        slv_done = 1'b0;
        @(posedge clk); #1;
        check_owner(0, "R8 new config");
        last_id = 0;
        @(negedge clk);
        mst_req = '0; slv_done = 1'b1;
        @(negedge clk);
        slv_done = 1'b0; mst_boost = '0;

        // R7: done while free has no effect
        slv_done = 1'b1;
        @(posedge clk); #1;
        chk(slv_valid == 1'b0, "R7 idle done", slv_valid, 0);
        @(negedge clk);
        slv_done = 1'b0;
        trial(4'hF, 4'h0, 1'b0, 8'h00, "R7 last kept");

        // R3 R5: every request and boost pattern, rotating mode
        for (int r = 1; r < 16; r++)
            for (int b = 0; b < 16; b++)
                trial(4'(r), 4'(b), 1'b0, 8'h00, (b == 0) ? "R3 rotate" : "R5 rotate boost");

        // R4 R5: programmed priority under eight patterns, including all-equal
        for (int s = 0; s < 8; s++) begin
            logic [7:0] p;
            p = (s == 0) ? 8'h00 : (s == 1) ? 8'hE4 : 8'(s * 37 + s * s * 11);
            for (int r = 1; r < 16; r++)
                for (int b = 0; b < 16; b++)
                    trial(4'(r), 4'(b), 1'b1, p, (b == 0) ? "R4 fixed" : "R5 fixed boost");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule